// File: doc/BRIEF.md
# I/O Space Wait-State Generator

This block stretches I/O-space bus cycles issued by a processor core. The I/O space holds 2048 locations, so only the low 11 bits of an access address matter. Address bits [10:9] split that space into four regions of 512 words each. Every region owns a 3-bit wait code. One global mode bit chooses how a code turns into a number of wait clocks, and that number can reach 15.

A request enters on a valid/ready handshake. The block takes a request only while `req_ready` is high, which is whenever no access is being stretched. A requester that sees `req_ready` low must hold `req_valid` and `req_addr` until a rising clock edge finds both valid and ready high. Once the block takes a request, it holds `busy` high for the computed number of clocks. A one-cycle `done` pulse follows. The wait count is fixed when the request is taken, so a later change to the configuration does not alter an access that is already running.

The configuration register sits on a simple write port at data address 0x3FFE. Its current contents are always visible on `cfg_rdata`. The layout is: region k code in bits [3k+2:3k], the mode bit in bit 15, and bits [14:12] reserved.

Top module: `io_wait_gen`

## Requirements
- R1: After reset `cfg_rdata` reads 0x8FFF (all four codes 7, mode bit 1), `req_ready` is 1, and `busy` and `done` are 0.
- R2: A write with `cfg_wr_en` high and `cfg_addr` equal to 0x3FFE loads the register on the next rising edge. A write to any other address leaves `cfg_rdata` and the wait timing unchanged.
- R3: Reserved bits [14:12] always read 0, whatever value is written to them.
- R4: `req_addr[10:9]` selects the region code (region k uses bits [3k+2:3k]). `req_addr` bits [13:11] have no effect on the wait count.
- R5: With the mode bit at 0, the wait count equals the region code N, giving 0 to 7 clocks.
- R6: With the mode bit at 1, the wait count is 2N+1, giving 1 to 15 clocks.
- R7: After a request is taken at an edge, `busy` is high for exactly W cycles and `done` is high for the single cycle that follows. When W is 0, `done` is high in the cycle right after the taking edge and `busy` stays low.
- R8: While `busy` is high, `req_ready` is low and no request is taken. A held request is taken at the first edge after `busy` falls.
- R9: A configuration write made while an access is being stretched does not change that access's wait count. It applies to later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 14 | Configuration write address |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current register contents, reserved bits as 0 |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 14 | Access address; only bits [10:0] are used |
| busy | output | 1 | Access is being stretched |
| done | output | 1 | One-cycle completion pulse |

## Verification
Accesses are issued under four configurations, each chosen to tell apart a different mistake:

- **Reset configuration.** Every region waits 15 clocks. This catches a wrong reset value or a wrong formula when the mode bit is 1.
- **Mixed codes 0, 1, 5 and 7 with the mode bit at 0.** Each region gets a distinct wait, so a swapped region decode or a wrong field slice changes the count. The code-0 region also covers back-to-back single-cycle completions.
- **The same codes with the mode bit at 1.** The expected waits are 1, 3, 11 and 15, which separates 2N+1 from N or 2N.
- **Addresses with bits [13:11] set.** These show whether the upper address bits leak into the decode.

Two further tests target the handshake and the latching of the wait count:

- A request is held while an access is busy, to expose a premature accept.
- A configuration write is made in the middle of a busy access, to expose a wait count that was not latched when the request was taken.

// File: rtl/iow_pkg.sv
package iow_pkg;
  localparam int unsigned IOW_REGIONS  = 4;
  localparam int unsigned IOW_FIELD_W  = 3;
  localparam int unsigned IOW_IO_AW    = 11;
  localparam int unsigned IOW_BUS_AW   = 14;
  localparam int unsigned IOW_DATA_W   = 16;
  localparam logic [IOW_BUS_AW-1:0] IOW_CFG_ADDR = 14'h3FFE;
endpackage

// File: rtl/iow_cfg_regs.sv
module iow_cfg_regs #(
  parameter int unsigned NREG    = 4,
  parameter int unsigned FIELD_W = 3,
  parameter int unsigned AW      = 14,
  parameter int unsigned DW      = 16,
  parameter logic [AW-1:0] ADDR  = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  output logic [DW-1:0]           rd_data,
  output logic [NREG*FIELD_W-1:0] codes,
  output logic                    mode
);
  localparam int unsigned MODE_BIT = DW - 1;
  localparam int unsigned USED_W   = NREG * FIELD_W;

  logic wr_hit;
  logic [FIELD_W-1:0] fld_q [NREG];
  logic mode_q;

  assign wr_hit = wr_en && (wr_addr == ADDR);

  for (genvar g = 0; g < NREG; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fld_q[g] <= '1;
      else if (wr_hit)
        fld_q[g] <= wr_data[g*FIELD_W +: FIELD_W];
    end
    assign codes[g*FIELD_W +: FIELD_W] = fld_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= 1'b1;
    else if (wr_hit)
      mode_q <= wr_data[MODE_BIT];
  end

  assign mode = mode_q;

  always_comb begin
    rd_data = '0;
    rd_data[USED_W-1:0] = codes;
    rd_data[MODE_BIT]   = mode_q;
  end

  // R2: without a matching write the stored value holds
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(rd_data));
  // R3: bits between the fields and the mode bit stay clear
  a_r3_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[MODE_BIT-1:USED_W] == '0);
endmodule

// File: rtl/iow_region_decode.sv
module iow_region_decode #(
  parameter int unsigned NREG    = 4,
  parameter int unsigned FIELD_W = 3,
  parameter int unsigned IO_AW   = 11,
  parameter int unsigned AW      = 14,
  parameter int unsigned CNT_W   = FIELD_W + 1
) (
  input  logic [AW-1:0]           addr,
  input  logic [NREG*FIELD_W-1:0] codes,
  input  logic                    mode,
  output logic [CNT_W-1:0]        wait_cnt
);
  localparam int unsigned RSEL_W = $clog2(NREG);

  logic [RSEL_W-1:0]  region;
  logic [FIELD_W-1:0] code;

  assign region = addr[IO_AW-1 -: RSEL_W];
  assign code   = codes[region*FIELD_W +: FIELD_W];

  always_comb begin
    if (mode)
      wait_cnt = {code, 1'b1};
    else
      wait_cnt = {1'b0, code};
  end
endmodule

// File: rtl/iow_wait_ctrl.sv
module iow_wait_ctrl #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] wait_cnt,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] remain_q;
  logic busy_q, done_q, take;

  assign req_ready = !busy_q;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      remain_q <= '0;
    end else if (busy_q) begin
      if (remain_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        remain_q <= remain_q - 1'b1;
        done_q   <= 1'b0;
      end
    end else if (take) begin
      if (wait_cnt == '0) begin
        done_q <= 1'b1;
      end else begin
        busy_q   <= 1'b1;
        remain_q <= wait_cnt - 1'b1;
        done_q   <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R8: busy may start only from a presented request
  a_r8_busy_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(req_valid));
  // R7: end of busy is always followed by the completion pulse
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R7: completion pulse and busy never overlap
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R8: while busy the remaining count only decreases
  a_r8_remain_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (remain_q < $past(remain_q)));
endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen
  import iow_pkg::*;
#(
  parameter int unsigned NREG    = IOW_REGIONS,
  parameter int unsigned FIELD_W = IOW_FIELD_W,
  parameter int unsigned IO_AW   = IOW_IO_AW,
  parameter int unsigned AW      = IOW_BUS_AW,
  parameter int unsigned DW      = IOW_DATA_W,
  parameter logic [AW-1:0] CFG_ADDR = IOW_CFG_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          done
);
  localparam int unsigned CNT_W = FIELD_W + 1;

  logic [NREG*FIELD_W-1:0] codes;
  logic                    mode;
  logic [CNT_W-1:0]        wait_cnt;

  iow_cfg_regs #(
    .NREG(NREG), .FIELD_W(FIELD_W), .AW(AW), .DW(DW), .ADDR(CFG_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .rd_data(cfg_rdata), .codes(codes), .mode(mode)
  );

  iow_region_decode #(
    .NREG(NREG), .FIELD_W(FIELD_W), .IO_AW(IO_AW), .AW(AW), .CNT_W(CNT_W)
  ) u_decode (
    .addr(req_addr), .codes(codes), .mode(mode), .wait_cnt(wait_cnt)
  );

  iow_wait_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .wait_cnt(wait_cnt), .busy(busy), .done(done)
  );

  // R8: the block never offers to take a request during a stretch
  a_r8_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
endmodule

// File: tb/test_io_wait_gen.sv
module test_io_wait_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [13:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_addr = '0;
  logic        busy, done;

  int total = 0;
  int bad = 0;
  logic [15:0] shadow = 16'h8FFF;
  int    exp_q[$];
  string tag_q[$];
  int    busy_run = 0;
  bit    finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_wait_gen i_io_wait_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_wait(input logic [13:0] a);
    int n;
    n = int'(shadow[a[10:9]*3 +: 3]);
    return shadow[15] ? 2*n + 1 : n;
  endfunction

  task automatic cfg_write(input logic [13:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (a == 14'h3FFE) shadow = d & 16'h8FFF;
  endtask

  task automatic check_rd(input string req);
    check(cfg_rdata == shadow, req, cfg_rdata, shadow);
  endtask

  // driver: hold request until taken, push expected wait at the taking edge
  task automatic issue(input logic [13:0] a, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(model_wait(a));
    tag_q.push_back(req);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: count busy cycles, compare at each done pulse
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (busy && req_ready) check(0, "R8 ready while busy", 1, 0);
      if (busy && done) check(0, "R7 done with busy", 1, 0);
      if (busy) busy_run++;
      if (done) begin
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected done", busy_run, -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(busy_run == e, t, busy_run, e);
        end
        busy_run = 0;
      end
    end
  end

  task automatic drain;
    while (exp_q.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cfg_rdata == 16'h8FFF, "R1 reset value", cfg_rdata, 16'h8FFF);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(busy == 1'b0 && done == 1'b0, "R1 busy/done idle", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // reset configuration: every region 15, upper address bits set (R4)
    issue(14'h0000, "R6 reset cfg region0");
    issue(14'h3A05, "R4 upper bits region1");
    issue(14'h0400, "R6 reset cfg region2");
    issue(14'h3FFF, "R4 upper bits region3");
    drain();

    // mode 0 codes 0,1,5,7
    cfg_write(14'h3FFE, 16'h0F48);
    check_rd("R2 write hit");
    issue(14'h0010, "R5 code0 zero wait");
    issue(14'h0011, "R7 zero wait back to back");
    issue(14'h0200, "R5 code1");
    issue(14'h05FF, "R5 code5");
    issue(14'h3E00, "R4 region3 upper bits");
    drain();

    // mode 1 same codes
    cfg_write(14'h3FFE, 16'h8F48);
    check_rd("R2 mode set");
    issue(14'h0000, "R6 code0");
    issue(14'h0300, "R6 code1");
    issue(14'h0500, "R6 code5");
    issue(14'h0700, "R6 code7");
    drain();

    // reserved bits
    cfg_write(14'h3FFE, 16'hFF48);
    check_rd("R3 reserved bits read zero");
    check(cfg_rdata[14:12] == 3'b000, "R3 reserved field", cfg_rdata[14:12], 0);

    // write to other address ignored
    cfg_write(14'h3FFD, 16'h0000);
    check_rd("R2 miss ignored");
    issue(14'h0400, "R2 timing after miss");
    drain();

    // held request while busy
    issue(14'h0600, "R8 first access");
    issue(14'h0200, "R8 held access");
    drain();

    // config change mid-access
    issue(14'h0600, "R9 latched count");
    cfg_write(14'h3FFE, 16'h0000);
    issue(14'h0600, "R9 new config applies");
    drain();
    check_rd("R9 readback");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule